// File: doc/BRIEF.md
# Integer Multiply Execute Unit

This unit sits in the execute stage of a 32-bit integer pipeline. It needs no clock. It takes the current instruction word and the two source operand values that were read for it. It recognises three multiply instructions and computes their product.

The short form multiplies the operands as signed numbers. It hands only the low word of the product to the general-register writeback port, and the destination index is taken from the instruction. The two wide forms multiply as signed or as unsigned numbers. They return the whole double-width product on the high-word and low-word result ports and raise both of those write enables.

Any other instruction, and an asserted reset, leave every output at zero. Signed products are formed by converting each operand to its magnitude, multiplying the magnitudes, and negating the product when exactly one operand was negative.

Top module: `mul_exec_unit`

## Requirements
- R1: With opcode bits [31:26] = 011100 and function bits [5:0] = 000010, the unit sets gpr_we = 1, drives gpr_waddr from the destination field, and drives gpr_wdata with the low 32 bits of the signed product rs_val × rt_val. In this case hi_we = lo_we = 0 and hi_wdata = lo_wdata = 0.
- R2: With opcode 000000 and function 011000, hi_wdata:lo_wdata carries the 64-bit signed product in two's complement, and hi_we = lo_we = 1.
- R3: With opcode 000000 and function 011001, hi_wdata:lo_wdata carries the 64-bit unsigned product, and hi_we = lo_we = 1.
- R4: The destination register index is taken from instruction bits [15:11]. The operand values come only from the rs_val and rt_val ports, so the rs and rt fields (bits [25:21] and [20:16]) do not change the result.
- R5: For both wide forms, gpr_we = 0, gpr_waddr = 0 and gpr_wdata = 0. A general-register write and a high/low write are never enabled together.
- R6: Any instruction word other than the three encodings above drives every enable to 0 and every data and address output to 0.
- R7: While rst = 1, every output is 0, whatever the instruction.
- R8: A signed product is negative exactly when the two original operand sign bits differ and neither operand is zero. The most negative operand squared (0x80000000 × 0x80000000) gives HI = 0x40000000 and LO = 0 in both the signed and the unsigned form.
- R9: For rs_val = 0x00000001 and rt_val = 0xFFFF0000, the results are as follows. The unsigned wide form gives HI = 0x00000000 and LO = 0xFFFF0000. The signed wide form gives HI = 0xFFFFFFFF and LO = 0xFFFF0000. The short form writes 0xFFFF0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset; forces all outputs to zero |
| instr | input | 32 | Instruction word in the execute stage |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| gpr_we | output | 1 | General-register writeback enable |
| gpr_waddr | output | 5 | General-register destination index |
| gpr_wdata | output | 32 | General-register writeback data |
| hi_we | output | 1 | High-word result write enable |
| hi_wdata | output | 32 | High word of the double-width product |
| lo_we | output | 1 | Low-word result write enable |
| lo_wdata | output | 32 | Low word of the double-width product |

## Verification
The assertions are evaluated every time the inputs settle. They cover the following:
- the two destinations are never enabled together, and the high and low enables always move as a pair;
- reset silences every output, and data stays zero whenever no enable is raised;
- a signed product's sign bit follows the operand signs, and any zero operand gives a zero product.

Some behaviour only the bench scenarios can show:
- that the numeric value of each product is correct;
- that the three encodings are told apart;
- that the destination comes from bits [15:11];
- the specific corner values, such as the most negative operand squared and the mixed-sign worked example.

// File: rtl/mul_exec_pkg.sv
package mul_exec_pkg;

  typedef enum logic [1:0] {
    MOP_NONE   = 2'd0,
    MOP_LOW_S  = 2'd1,
    MOP_WIDE_S = 2'd2,
    MOP_WIDE_U = 2'd3
  } mop_e;

  localparam int OPC_W  = 6;
  localparam int FUNC_W = 6;
  localparam int RD_LSB = 11;

  localparam logic [OPC_W-1:0]  OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0]  OPC_EXT2  = 6'b011100;
  localparam logic [FUNC_W-1:0] FN_LOW_S  = 6'b000010;
  localparam logic [FUNC_W-1:0] FN_WIDE_S = 6'b011000;
  localparam logic [FUNC_W-1:0] FN_WIDE_U = 6'b011001;

endpackage

// File: rtl/mul_decode.sv
module mul_decode
  import mul_exec_pkg::*;
#(
  parameter int INSTR_W    = 32,
  parameter int REG_ADDR_W = 5
) (
  input  logic [INSTR_W-1:0]    instr,
  output mop_e                  mop,
  output logic                  op_signed,
  output logic [REG_ADDR_W-1:0] dest_addr
);

  localparam int RD_MSB = RD_LSB + REG_ADDR_W - 1;

  logic [OPC_W-1:0]  opc;
  logic [FUNC_W-1:0] fn;
  logic              unused_fields;

  assign opc           = instr[INSTR_W-1 -: OPC_W];
  assign fn            = instr[FUNC_W-1:0];
  assign dest_addr     = instr[RD_MSB:RD_LSB];
  assign unused_fields = ^{instr[INSTR_W-OPC_W-1:RD_MSB+1], instr[RD_LSB-1:FUNC_W]};

  always_comb begin
    mop = MOP_NONE;
    if (opc == OPC_EXT2 && fn == FN_LOW_S) begin
      mop = MOP_LOW_S;
    end else if (opc == OPC_REG) begin
      case (fn)
        FN_WIDE_S: mop = MOP_WIDE_S;
        FN_WIDE_U: mop = MOP_WIDE_U;
        default:   mop = MOP_NONE;
      endcase
    end
  end

  assign op_signed = (mop == MOP_LOW_S) || (mop == MOP_WIDE_S);

endmodule

// File: rtl/mul_core.sv
module mul_core #(
  parameter int DATA_W = 32,
  parameter int STYLE  = 0
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic                is_signed,
  output logic [2*DATA_W-1:0] product,
  output logic                neg_result
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int MSB    = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE_D = 1;
  localparam logic [PROD_W-1:0] ONE_P = 1;

  function automatic logic [DATA_W-1:0] magnitude(input logic [DATA_W-1:0] v);
    return v[MSB] ? ((~v) + ONE_D) : v;
  endfunction

  function automatic logic [PROD_W-1:0] negate_wide(input logic [PROD_W-1:0] v);
    return (~v) + ONE_P;
  endfunction

  assign neg_result = is_signed && (op_a[MSB] ^ op_b[MSB]);

  generate
    if (STYLE == 0) begin : g_magnitude
      logic [DATA_W-1:0] mag_a;
      logic [DATA_W-1:0] mag_b;
      logic [PROD_W-1:0] raw;
      assign mag_a   = is_signed ? magnitude(op_a) : op_a;
      assign mag_b   = is_signed ? magnitude(op_b) : op_b;
      assign raw     = {{DATA_W{1'b0}}, mag_a} * {{DATA_W{1'b0}}, mag_b};
      assign product = neg_result ? negate_wide(raw) : raw;
    end else begin : g_extend
      logic [PROD_W-1:0] ext_a;
      logic [PROD_W-1:0] ext_b;
      assign ext_a   = {{DATA_W{is_signed & op_a[MSB]}}, op_a};
      assign ext_b   = {{DATA_W{is_signed & op_b[MSB]}}, op_b};
      assign product = ext_a * ext_b;
    end
  endgenerate

  always_comb begin
    if (is_signed && op_a != '0 && op_b != '0) begin
      p_sign_follows_r8: assert (product[PROD_W-1] == neg_result)
        else $error("R8: product sign %0b, operand signs imply %0b", product[PROD_W-1], neg_result);
    end
    if (op_a == '0 || op_b == '0) begin
      p_zero_operand_r8: assert (product == '0)
        else $error("R8: zero operand gave non-zero product %h", product);
    end
  end

endmodule

// File: rtl/mul_route.sv
module mul_route
  import mul_exec_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REG_ADDR_W = 5
) (
  input  logic                  rst,
  input  mop_e                  mop,
  input  logic [REG_ADDR_W-1:0] dest_addr,
  input  logic [2*DATA_W-1:0]   product,
  output logic                  gpr_we,
  output logic [REG_ADDR_W-1:0] gpr_waddr,
  output logic [DATA_W-1:0]     gpr_wdata,
  output logic                  hi_we,
  output logic [DATA_W-1:0]     hi_wdata,
  output logic                  lo_we,
  output logic [DATA_W-1:0]     lo_wdata
);

  logic [DATA_W-1:0] prod_hi;
  logic [DATA_W-1:0] prod_lo;

  assign prod_hi = product[2*DATA_W-1:DATA_W];
  assign prod_lo = product[DATA_W-1:0];

  always_comb begin
    gpr_we    = 1'b0;
    gpr_waddr = '0;
    gpr_wdata = '0;
    hi_we     = 1'b0;
    hi_wdata  = '0;
    lo_we     = 1'b0;
    lo_wdata  = '0;
    if (!rst) begin
      case (mop)
        MOP_LOW_S: begin
          gpr_we    = 1'b1;
          gpr_waddr = dest_addr;
          gpr_wdata = prod_lo;
        end
        MOP_WIDE_S, MOP_WIDE_U: begin
          hi_we    = 1'b1;
          hi_wdata = prod_hi;
          lo_we    = 1'b1;
          lo_wdata = prod_lo;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mul_exec_unit.sv
module mul_exec_unit
  import mul_exec_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REG_ADDR_W = 5,
  parameter int INSTR_W    = 32,
  parameter int MULT_STYLE = 0
) (
  input  logic                  rst,
  input  logic [INSTR_W-1:0]    instr,
  input  logic [DATA_W-1:0]     rs_val,
  input  logic [DATA_W-1:0]     rt_val,
  output logic                  gpr_we,
  output logic [REG_ADDR_W-1:0] gpr_waddr,
  output logic [DATA_W-1:0]     gpr_wdata,
  output logic                  hi_we,
  output logic [DATA_W-1:0]     hi_wdata,
  output logic                  lo_we,
  output logic [DATA_W-1:0]     lo_wdata
);

  mop_e                  mop;
  logic                  op_signed;
  logic [REG_ADDR_W-1:0] dest_addr;
  logic [2*DATA_W-1:0]   product;
  logic                  neg_result;

  mul_decode #(
    .INSTR_W   (INSTR_W),
    .REG_ADDR_W(REG_ADDR_W)
  ) u_decode (
    .instr    (instr),
    .mop      (mop),
    .op_signed(op_signed),
    .dest_addr(dest_addr)
  );

  mul_core #(
    .DATA_W(DATA_W),
    .STYLE (MULT_STYLE)
  ) u_core (
    .op_a      (rs_val),
    .op_b      (rt_val),
    .is_signed (op_signed),
    .product   (product),
    .neg_result(neg_result)
  );

  mul_route #(
    .DATA_W    (DATA_W),
    .REG_ADDR_W(REG_ADDR_W)
  ) u_route (
    .rst      (rst),
    .mop      (mop),
    .dest_addr(dest_addr),
    .product  (product),
    .gpr_we   (gpr_we),
    .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata),
    .hi_we    (hi_we),
    .hi_wdata (hi_wdata),
    .lo_we    (lo_we),
    .lo_wdata (lo_wdata)
  );

  always_comb begin
    p_we_exclusive_r5: assert (!(gpr_we && (hi_we || lo_we)))
      else $error("R5: general and high/low writes enabled together");
    p_hilo_pair_r2: assert (hi_we == lo_we)
      else $error("R2: high enable %0b differs from low enable %0b", hi_we, lo_we);
    if (rst) begin
      p_rst_quiet_r7: assert (!gpr_we && !hi_we && !lo_we && gpr_waddr == '0 &&
                              gpr_wdata == '0 && hi_wdata == '0 && lo_wdata == '0)
        else $error("R7: outputs active during reset");
    end
    if (!gpr_we && !hi_we) begin
      p_idle_zero_r6: assert (gpr_waddr == '0 && gpr_wdata == '0 &&
                              hi_wdata == '0 && lo_wdata == '0)
        else $error("R6: data driven with no enable raised");
    end
    if (hi_we) begin
      p_wide_no_gpr_r5: assert (gpr_waddr == '0 && gpr_wdata == '0)
        else $error("R5: general port driven during a wide multiply");
    end
  end

endmodule

// File: tb/mul_exec_unit_tb.sv
module mul_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic        gpr_we;
  logic [4:0]  gpr_waddr;
  logic [31:0] gpr_wdata;
  logic        hi_we;
  logic [31:0] hi_wdata;
  logic        lo_we;
  logic [31:0] lo_wdata;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mul_exec_unit dut_i (
    .rst      (rst),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .gpr_we   (gpr_we),
    .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata),
    .hi_we    (hi_we),
    .hi_wdata (hi_wdata),
    .lo_we    (lo_we),
    .lo_wdata (lo_wdata)
  );

  // kind: 0 short signed, 1 wide signed, 2 wide unsigned, 3+ illegal variants
  function automatic logic [31:0] build(input int kind, input logic [4:0] rsf,
                                       input logic [4:0] rtf, input logic [4:0] rdf);
    logic [5:0] op;
    logic [5:0] fn;
    case (kind)
      0: begin op = 6'b011100; fn = 6'b000010; end
      1: begin op = 6'b000000; fn = 6'b011000; end
      2: begin op = 6'b000000; fn = 6'b011001; end
      3: begin op = 6'b000000; fn = 6'b011010; end
      4: begin op = 6'b011100; fn = 6'b011000; end
      5: begin op = 6'b000001; fn = 6'b000010; end
      default: begin op = 6'b000000; fn = 6'b000010; end
    endcase
    return {op, rsf, rtf, rdf, 5'd0, fn};
  endfunction

  function automatic logic [63:0] ref_prod(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    longint          sa;
    longint          sb;
    longint unsigned ua;
    longint unsigned ub;
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    ua = 64'(a);
    ub = 64'(b);
    return ua * ub;
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input bit r, input int kind, input logic [4:0] rdf,
                       input logic [31:0] a, input logic [31:0] b, input string req);
    logic [63:0] p;
    bit e_g;
    bit e_w;
    @(negedge clk);
    rst    = r;
    instr  = build(kind, 5'($urandom), 5'($urandom), rdf);
    rs_val = a;
    rt_val = b;
    #1;
    p   = ref_prod(kind != 2, a, b);
    e_g = !r && kind == 0;
    e_w = !r && (kind == 1 || kind == 2);
    cmp(req, "gpr_we",    64'(gpr_we),    64'(e_g));
    cmp(req, "gpr_waddr", 64'(gpr_waddr), e_g ? 64'(rdf) : 64'd0);
    cmp(req, "gpr_wdata", 64'(gpr_wdata), e_g ? 64'(p[31:0]) : 64'd0);
    cmp(req, "hi_we",     64'(hi_we),     64'(e_w));
    cmp(req, "lo_we",     64'(lo_we),     64'(e_w));
    cmp(req, "hi_wdata",  64'(hi_wdata),  e_w ? 64'(p[63:32]) : 64'd0);
    cmp(req, "lo_wdata",  64'(lo_wdata),  e_w ? 64'(p[31:0]) : 64'd0);
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #40000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; instr = '0; rs_val = '0; rt_val = '0;

    // R7: reset silences every form
    apply(1'b1, 1, 5'd9,  32'h1234_5678, 32'h9ABC_DEF0, "R7");
    apply(1'b1, 0, 5'd31, 32'hFFFF_FFFF, 32'h0000_0002, "R7");

    // R9: worked example, all three forms
    apply(1'b0, 2, 5'd0, 32'h0000_0001, 32'hFFFF_0000, "R9");
    cmp("R9", "multu hi", 64'(hi_wdata), 64'h0);
    cmp("R9", "multu lo", 64'(lo_wdata), 64'hFFFF_0000);
    apply(1'b0, 1, 5'd0, 32'h0000_0001, 32'hFFFF_0000, "R9");
    cmp("R9", "mult hi", 64'(hi_wdata), 64'hFFFF_FFFF);
    cmp("R9", "mult lo", 64'(lo_wdata), 64'hFFFF_0000);
    apply(1'b0, 0, 5'd3, 32'h0000_0001, 32'hFFFF_0000, "R9");
    cmp("R9", "mul rd data", 64'(gpr_wdata), 64'hFFFF_0000);

    // R8: most negative operand squared, sign rule
    apply(1'b0, 1, 5'd0, 32'h8000_0000, 32'h8000_0000, "R8");
    cmp("R8", "signed hi", 64'(hi_wdata), 64'h4000_0000);
    cmp("R8", "signed lo", 64'(lo_wdata), 64'h0);
    apply(1'b0, 2, 5'd0, 32'h8000_0000, 32'h8000_0000, "R8");
    cmp("R8", "unsigned hi", 64'(hi_wdata), 64'h4000_0000);
    apply(1'b0, 1, 5'd0, 32'hFFFF_FFFF, 32'h0000_0000, "R8");
    apply(1'b0, 1, 5'd0, 32'h8000_0000, 32'h7FFF_FFFF, "R8");
    cmp("R8", "neg sign", 64'(hi_wdata[31]), 64'd1);
    apply(1'b0, 1, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    apply(1'b0, 2, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    cmp("R3", "max unsigned hi", 64'(hi_wdata), 64'hFFFF_FFFE);

    // R4: destination field bits [15:11], edge indices
    apply(1'b0, 0, 5'd31, 32'd7, 32'd6, "R4");
    apply(1'b0, 0, 5'd0,  32'd7, 32'd6, "R4");
    apply(1'b0, 0, 5'd16, 32'hFFFF_FFF9, 32'd6, "R1");

    // R6: illegal encodings
    for (int k = 3; k <= 6; k++) apply(1'b0, k, 5'd21, 32'h1111_1111, 32'h2222_2222, "R6");

    // R7: leaving reset restores function
    apply(1'b1, 2, 5'd4, 32'hDEAD_BEEF, 32'h0BAD_F00D, "R7");
    apply(1'b0, 2, 5'd4, 32'hDEAD_BEEF, 32'h0BAD_F00D, "R3");

    // random mix: R1 R2 R3 R5 R6
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 6);
      apply(($urandom_range(0, 19) == 0), k, 5'($urandom), pick_operand(), pick_operand(),
            k == 0 ? "R1" : k == 1 ? "R2" : k == 2 ? "R3" : "R6");
      if (k == 1 || k == 2) cmp("R5", "no gpr on wide", 64'(gpr_we), 64'd0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule